// File: doc/BRIEF.md
# Multiplexed Bus Access Sequencer

This block is a host-side bus master. It takes one register request at a time and turns it into a cycle on a shared address/data bus driven with 80xx-style strobes. A request carries a register address, a write flag and write data. The sequencer first puts the address on the shared lines with the chip select low and the address latch enable high. It then drops the latch enable, holds the address briefly and runs the data phase with either the write strobe or the read strobe. Read data is taken from the bus on the edge that ends the read strobe and is returned with a one-cycle done pulse.

Every nanosecond limit of the bus is a parameter in picoseconds. Each is rounded up to whole system-clock cycles at elaboration. Some accesses need a longer gap before the next strobe, and that gap is counted in arbitration periods. One arbitration period is one operating-clock period when slow arbitration is off and two when it is on, also rounded up to system cycles. The request handshake holds off the next request until the gap needed for that request has passed.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset, cs_n, wr_n and rd_n are 1, ale, bus_oe and done are 0, and req_ready is 1.
- R2: When a request is accepted (req_valid and req_ready high at a clock edge), the next cycle starts an address phase. In that phase ale is 1, cs_n is 0 and bus_oe is 1 for A = ceil(max(20 ns address setup, 10 ns select setup, 20 ns latch-high width) / Tsys) cycles, which is 5 at the defaults. bus_out carries the zero-extended request address, and that value is the one latched when ale falls.
- R3: Once ale falls, the address stays on bus_out for ceil(10 ns / Tsys) cycles. The data strobe falls L = max(ceil(max(15 ns, 20 ns) / Tsys), hold + 1) cycles after ale falls, which is 5 at the defaults.
- R4: A write holds wr_n low for ceil(max(20 ns, 30 ns data setup) / Tsys) = 8 cycles with the write data on bus_out. After wr_n rises, cs_n stays low and the write data stays driven for ceil(10 ns / Tsys) = 3 cycles.
- R5: A read holds rd_n low for ceil(20 ns / Tsys) = 5 cycles. bus_oe is 0 in every cycle in which rd_n is low and in the hold cycles that follow.
- R6: The value on bus_in in the last cycle of rd_n low appears on rdata. done is a single-cycle pulse in the first cycle after the strobe rises, and it pulses for writes as well as reads.
- R7: wr_n and rd_n are never low together. A strobe is low only while ale is 0 and cs_n is 0, and ale is high only while cs_n is 0.
- R8: When no spacing rule applies and requests are presented back to back, the gap between one strobe rising and the next falling is exactly H + 1 + A + L = 14 high cycles.
- R9: After a write to the pointer-low register (address 2 by default), the next strobe stays high for at least 4 arbitration periods. With back-to-back requests the gap is exactly max(14, 4 x arb).
- R10: A write to the pointer-low register that follows a write or a read of the data register (address 4 by default) waits at least 5 arbitration periods. With back-to-back requests the gap is exactly max(14, 5 x arb).
- R11: One arbitration period is ceil(Topr / Tsys) cycles when slow_arb is 0 and ceil(2 x Topr / Tsys) cycles when slow_arb is 1. That is 4 and 7 cycles at the defaults (Tsys = 4 ns, Topr = 12.5 ns).
- R12: req_ready is high only while no cycle is in progress and the gap needed for the presented request is met. It is therefore low in the cycle after an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_arb | input | 1 | Doubles the arbitration period when 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle pulse when an access finishes |
| rdata | output | DATA_W | Data captured by the last read |
| ale | output | 1 | Address latch enable, active high |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_oe | output | 1 | Enable for the shared-line drivers |
| bus_out | output | DATA_W | Value driven on the shared lines |
| bus_in | input | DATA_W | Value read back from the shared lines |

## Verification
The bound checker watches, on every cycle, the orderings that hold in all states. It checks that the strobes are exclusive, that strobes and the latch enable only occur under chip select, that the drivers are off during a read strobe, that done is a single pulse, that ready stays low during a cycle, and that the pointer-write gap is never shorter than four fast arbitration periods. The exact cycle counts can only be shown by the bench's sweep over every pair of access kinds under both arbitration settings. These are the phase widths, the exact back-to-back gap for each previous/next combination, the returned read data and the written data.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_LATCH,
      PH_STRB,
      PH_HOLD
   } phase_e;

   typedef enum logic [2:0] {
      AK_NONE,
      AK_PTR_WR,
      AK_DATA_WR,
      AK_DATA_RD,
      AK_OTHER
   } acc_kind_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
   import mbs_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned A_CYC  = 5,
   parameter int unsigned L_CYC  = 5,
   parameter int unsigned SW_CYC = 8,
   parameter int unsigned SR_CYC = 5,
   parameter int unsigned H_CYC  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_write,
   output phase_e           phase,
   output logic [CNT_W-1:0] cnt,
   output logic             is_write,
   output logic             strb_last
);

   logic [CNT_W-1:0] len;
   logic             ph_end;
   phase_e           ph_next;

   always_comb begin
      case (phase)
         PH_ADDR:  len = CNT_W'(A_CYC);
         PH_LATCH: len = CNT_W'(L_CYC);
         PH_STRB:  len = is_write ? CNT_W'(SW_CYC) : CNT_W'(SR_CYC);
         PH_HOLD:  len = CNT_W'(H_CYC);
         default:  len = CNT_W'(1);
      endcase
   end

   always_comb begin
      case (phase)
         PH_ADDR:  ph_next = PH_LATCH;
         PH_LATCH: ph_next = PH_STRB;
         PH_STRB:  ph_next = PH_HOLD;
         default:  ph_next = PH_IDLE;
      endcase
   end

   assign ph_end    = (cnt == len - 1'b1);
   assign strb_last = (phase == PH_STRB) && ph_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         is_write <= 1'b0;
      end else if (phase == PH_IDLE) begin
         cnt <= '0;
         if (start) begin
            phase    <= PH_ADDR;
            is_write <= start_write;
         end
      end else if (ph_end) begin
         cnt   <= '0;
         phase <= ph_next;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/mbs_spacing.sv
module mbs_spacing
   import mbs_pkg::*;
#(
   parameter int unsigned ADDR_W             = 3,
   parameter int unsigned PTR_LO_ADDR        = 2,
   parameter int unsigned DATA_REG_ADDR      = 4,
   parameter int unsigned ARB_F              = 4,
   parameter int unsigned ARB_S              = 7,
   parameter int unsigned PTR_GAP_ARB        = 4,
   parameter int unsigned PTR_AFTER_DATA_ARB = 5,
   parameter int unsigned LEAD               = 11,
   parameter int unsigned GAP_W              = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_arb,
   input  logic              strobe_low,
   input  logic              accept,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              gap_ok
);

   acc_kind_e        prev_kind;
   acc_kind_e        next_kind;
   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] arb_c;
   logic [GAP_W-1:0] periods;
   logic [GAP_W-1:0] need;

   always_comb begin
      if (req_addr == ADDR_W'(PTR_LO_ADDR) && req_write)
         next_kind = AK_PTR_WR;
      else if (req_addr == ADDR_W'(DATA_REG_ADDR))
         next_kind = req_write ? AK_DATA_WR : AK_DATA_RD;
      else
         next_kind = AK_OTHER;
   end

   // high cycles since the last strobe ended; saturates so reset reads as "long ago"
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gap_q <= '1;
      else if (strobe_low)
         gap_q <= '0;
      else if (gap_q != '1)
         gap_q <= gap_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_kind <= AK_NONE;
      else if (accept)
         prev_kind <= next_kind;
   end

   always_comb begin
      arb_c = slow_arb ? GAP_W'(ARB_S) : GAP_W'(ARB_F);
      if (prev_kind == AK_PTR_WR)
         periods = GAP_W'(PTR_GAP_ARB);
      else if (next_kind == AK_PTR_WR &&
               (prev_kind == AK_DATA_WR || prev_kind == AK_DATA_RD))
         periods = GAP_W'(PTR_AFTER_DATA_ARB);
      else
         periods = '0;
      need = periods * arb_c;
   end

   // the new strobe falls LEAD cycles after an accept in this cycle
   assign gap_ok = ({1'b0, gap_q} + (GAP_W + 1)'(LEAD)) >= {1'b0, need};

endmodule

// File: rtl/mbs_bus_io.sv
module mbs_bus_io
   import mbs_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned HLD_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  phase_e            phase,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              is_write,
   input  logic              strb_last,
   input  logic [DATA_W-1:0] bus_in,
   output logic              ale,
   output logic              cs_n,
   output logic              wr_n,
   output logic              rd_n,
   output logic              bus_oe,
   output logic [DATA_W-1:0] bus_out,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              addr_drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= strb_last;
         if (strb_last && !is_write)
            rdata <= bus_in;
      end
   end

   assign addr_drive = (phase == PH_ADDR) ||
                       (phase == PH_LATCH && cnt < CNT_W'(HLD_CYC));

   assign ale    = (phase == PH_ADDR);
   assign cs_n   = (phase == PH_IDLE);
   assign wr_n   = !(phase == PH_STRB && is_write);
   assign rd_n   = !(phase == PH_STRB && !is_write);
   assign bus_oe = (phase != PH_IDLE) && (addr_drive || is_write);

   always_comb begin
      if (addr_drive)
         bus_out = DATA_W'(addr_q);
      else if (is_write && phase != PH_IDLE)
         bus_out = wdata_q;
      else
         bus_out = '0;
   end

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
   import mbs_pkg::*;
#(
   parameter int unsigned DATA_W             = 8,
   parameter int unsigned ADDR_W             = 3,
   parameter int unsigned PTR_LO_ADDR        = 2,
   parameter int unsigned DATA_REG_ADDR      = 4,
   parameter int unsigned SYS_CLK_PS         = 4000,
   parameter int unsigned OPR_CLK_PS         = 12500,
   parameter int unsigned ADR_SETUP_PS       = 20000,
   parameter int unsigned ADR_HOLD_PS        = 10000,
   parameter int unsigned CS_SETUP_PS        = 10000,
   parameter int unsigned ALE_HI_PS          = 20000,
   parameter int unsigned ALE_LO_PS          = 20000,
   parameter int unsigned ALE_TO_STB_PS      = 15000,
   parameter int unsigned WD_SETUP_PS        = 30000,
   parameter int unsigned WD_HOLD_PS         = 10000,
   parameter int unsigned STB_LO_PS          = 20000,
   parameter int unsigned STB_HI_PS          = 20000,
   parameter int unsigned PTR_GAP_ARB        = 4,
   parameter int unsigned PTR_AFTER_DATA_ARB = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_arb,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              ale,
   output logic              cs_n,
   output logic              wr_n,
   output logic              rd_n,
   output logic              bus_oe,
   output logic [DATA_W-1:0] bus_out,
   input  logic [DATA_W-1:0] bus_in
);

   localparam int unsigned A_CYC   = ceil_div(max2(max2(ADR_SETUP_PS, CS_SETUP_PS), ALE_HI_PS), SYS_CLK_PS);
   localparam int unsigned HLD_CYC = max2(ceil_div(ADR_HOLD_PS, SYS_CLK_PS), 1);
   localparam int unsigned L_CYC   = max2(ceil_div(max2(ALE_TO_STB_PS, ALE_LO_PS), SYS_CLK_PS), HLD_CYC + 1);
   localparam int unsigned SW_CYC  = ceil_div(max2(STB_LO_PS, WD_SETUP_PS), SYS_CLK_PS);
   localparam int unsigned SR_CYC  = max2(ceil_div(STB_LO_PS, SYS_CLK_PS), 1);
   localparam int unsigned H_CYC   = max2(ceil_div(WD_HOLD_PS, SYS_CLK_PS), 1);
   localparam int unsigned ARB_F   = ceil_div(OPR_CLK_PS, SYS_CLK_PS);
   localparam int unsigned ARB_S   = ceil_div(2 * OPR_CLK_PS, SYS_CLK_PS);
   localparam int unsigned LEAD    = 1 + A_CYC + L_CYC;
   localparam int unsigned NAT_GAP = H_CYC + LEAD;
   localparam int unsigned MAX_NEED = max2(PTR_GAP_ARB, PTR_AFTER_DATA_ARB) * ARB_S;
   localparam int unsigned GAP_W   = $clog2(MAX_NEED + NAT_GAP + 2) + 1;
   localparam int unsigned MAX_PH  = max2(max2(A_CYC, L_CYC), max2(max2(SW_CYC, SR_CYC), H_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_PH + 1);

   if (ADDR_W > DATA_W) begin : g_bad_width
      $error("address must fit on the shared data lines");
   end
   if (PTR_LO_ADDR == DATA_REG_ADDR) begin : g_bad_map
      $error("pointer and data register addresses must differ");
   end
   if (NAT_GAP * SYS_CLK_PS < STB_HI_PS) begin : g_bad_gap
      $error("natural strobe spacing shorter than strobe high minimum");
   end
   if (PTR_LO_ADDR >= (1 << ADDR_W) || DATA_REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register address outside address width");
   end

   phase_e           phase;
   logic [CNT_W-1:0] cnt;
   logic             is_write;
   logic             strb_last;
   logic             gap_ok;
   logic             accept;

   assign req_ready = (phase == PH_IDLE) && gap_ok;
   assign accept    = req_valid && req_ready;

   mbs_phase_fsm #(
      .CNT_W (CNT_W),
      .A_CYC (A_CYC),
      .L_CYC (L_CYC),
      .SW_CYC(SW_CYC),
      .SR_CYC(SR_CYC),
      .H_CYC (H_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_write(req_write),
      .phase      (phase),
      .cnt        (cnt),
      .is_write   (is_write),
      .strb_last  (strb_last)
   );

   mbs_spacing #(
      .ADDR_W            (ADDR_W),
      .PTR_LO_ADDR       (PTR_LO_ADDR),
      .DATA_REG_ADDR     (DATA_REG_ADDR),
      .ARB_F             (ARB_F),
      .ARB_S             (ARB_S),
      .PTR_GAP_ARB       (PTR_GAP_ARB),
      .PTR_AFTER_DATA_ARB(PTR_AFTER_DATA_ARB),
      .LEAD              (LEAD),
      .GAP_W             (GAP_W)
   ) u_spacing (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_arb  (slow_arb),
      .strobe_low(!wr_n || !rd_n),
      .accept    (accept),
      .req_write (req_write),
      .req_addr  (req_addr),
      .gap_ok    (gap_ok)
   );

   mbs_bus_io #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .HLD_CYC(HLD_CYC)
   ) u_io (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .phase    (phase),
      .cnt      (cnt),
      .is_write (is_write),
      .strb_last(strb_last),
      .bus_in   (bus_in),
      .ale      (ale),
      .cs_n     (cs_n),
      .wr_n     (wr_n),
      .rd_n     (rd_n),
      .bus_oe   (bus_oe),
      .bus_out  (bus_out),
      .rdata    (rdata),
      .done     (done)
   );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
   import mbs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned PTR_LO_ADDR = 2,
   parameter int unsigned SYS_CLK_PS  = 4000,
   parameter int unsigned OPR_CLK_PS  = 12500,
   parameter int unsigned PTR_GAP_ARB = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              ale,
   input logic              cs_n,
   input logic              wr_n,
   input logic              rd_n,
   input logic              bus_oe,
   input logic [ADDR_W-1:0] lat_bus
);

   localparam int unsigned ARB_F = ceil_div(OPR_CLK_PS, SYS_CLK_PS);

   logic              strb_any;
   logic              strb_d;
   logic [15:0]       hi_cnt;
   logic [ADDR_W-1:0] lat_q;
   logic              prev_ptr;

   assign strb_any = !wr_n || !rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_d   <= 1'b0;
         hi_cnt   <= '1;
         lat_q    <= '0;
         prev_ptr <= 1'b0;
      end else begin
         strb_d <= strb_any;
         if (strb_any)
            hi_cnt <= '0;
         else if (hi_cnt != '1)
            hi_cnt <= hi_cnt + 1'b1;
         if (ale)
            lat_q <= lat_bus;
         if (!wr_n)
            prev_ptr <= (lat_q == ADDR_W'(PTR_LO_ADDR));
         else if (!rd_n)
            prev_ptr <= 1'b0;
      end
   end

   // R5
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !bus_oe);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!wr_n && !rd_n));

   // R7
   strobe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb_any |-> (!ale && !cs_n));

   // R7
   ale_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> !cs_n);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs_n && !ale));

   // R9
   ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_any && !strb_d && prev_ptr) |-> (hi_cnt >= 16'(PTR_GAP_ARB * ARB_F)));

endmodule

bind mux_bus_sequencer mbs_checker #(
   .ADDR_W     (ADDR_W),
   .PTR_LO_ADDR(PTR_LO_ADDR),
   .SYS_CLK_PS (SYS_CLK_PS),
   .OPR_CLK_PS (OPR_CLK_PS),
   .PTR_GAP_ARB(PTR_GAP_ARB)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .done     (done),
   .ale      (ale),
   .cs_n     (cs_n),
   .wr_n     (wr_n),
   .rd_n     (rd_n),
   .bus_oe   (bus_oe),
   .lat_bus  (bus_out[ADDR_W-1:0])
);

// File: tb/mux_bus_sequencer_bench.sv
`timescale 1ns/1ps
module mux_bus_sequencer_bench;

   localparam int SYS_PS = 4000;
   localparam int OPR_PS = 12500;
   localparam int A_EXP  = (20000 + SYS_PS - 1) / SYS_PS;
   localparam int L_EXP  = (20000 + SYS_PS - 1) / SYS_PS;
   localparam int SW_EXP = (30000 + SYS_PS - 1) / SYS_PS;
   localparam int SR_EXP = (20000 + SYS_PS - 1) / SYS_PS;
   localparam int H_EXP  = (10000 + SYS_PS - 1) / SYS_PS;
   localparam int NAT    = H_EXP + 1 + A_EXP + L_EXP;
   localparam int ARB_F  = (OPR_PS + SYS_PS - 1) / SYS_PS;
   localparam int ARB_S  = (2 * OPR_PS + SYS_PS - 1) / SYS_PS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_arb = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_write = 1'b0;
   logic [2:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       done;
   logic [7:0] rdata;
   logic       ale, cs_n, wr_n, rd_n, bus_oe;
   logic [7:0] bus_out;
   logic [7:0] bus_in;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mux_bus_sequencer u_mux_bus_sequencer (
      .clk(clk), .rst_n(rst_n), .slow_arb(slow_arb),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
      .ale(ale), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .bus_oe(bus_oe),
      .bus_out(bus_out), .bus_in(bus_in)
   );

   // monitor state
   int         hi_cnt = 9999, low_cnt = 0, ale_cnt = 0, ats = 0;
   int         last_gap = 0, last_low_w = 0, last_ale_w = 0, last_ats = 0;
   int         post_cnt = 0, post_drv = 0, oe_bad = 0, both_low = 0;
   int         done_cnt = 0, done_long = 0;
   bit         strb_d = 0, ale_d = 0, done_d = 0, in_pre = 0, in_post = 0;
   logic [2:0] lat_addr = '0;
   logic [7:0] wd_seen = '0, done_rdata = '0;
   logic [4:0] seed = '0;

   function automatic logic [7:0] rd_val(input logic [2:0] a, input logic [4:0] s);
      return 8'h5A ^ {s, a};
   endfunction

   // peripheral model: answers reads with a pattern of the latched address
   assign bus_in = !rd_n ? rd_val(lat_addr, seed) : 8'h00;

   always @(negedge clk) begin
      bit strb;
      strb = !wr_n || !rd_n;
      if (strb && !strb_d) begin
         last_gap = hi_cnt; last_ats = ats; in_pre = 0; low_cnt = 0;
      end
      if (!strb && strb_d) begin
         last_low_w = low_cnt; in_post = 1; post_cnt = 0; post_drv = 0;
      end
      if (strb) begin
         hi_cnt = 0; low_cnt++;
         if (!wr_n) wd_seen = bus_out;
         if (!rd_n && bus_oe) oe_bad++;
         if (!wr_n && !rd_n) both_low++;
      end else if (hi_cnt < 9999) hi_cnt++;
      if (in_post) begin
         if (cs_n) in_post = 0;
         else begin
            post_cnt++;
            if (bus_oe && bus_out == wd_seen) post_drv++;
         end
      end
      if (ale) begin ale_cnt++; lat_addr = bus_out[2:0]; end
      if (!ale && ale_d) begin last_ale_w = ale_cnt; ale_cnt = 0; in_pre = 1; ats = 0; end
      if (in_pre) ats++;
      if (done) begin
         done_cnt++; done_rdata = rdata;
         if (done_d) done_long++;
      end
      strb_d = strb; ale_d = ale; done_d = done;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // op codes: 0 pointer-low write, 1 data write, 2 data read, 3 other write, 4 other read
   function automatic logic [2:0] op_addr(input int op);
      case (op)
         0: return 3'd2;
         1, 2: return 3'd4;
         3: return 3'd1;
         default: return 3'd7;
      endcase
   endfunction

   function automatic bit op_wr(input int op);
      return (op == 0 || op == 1 || op == 3);
   endfunction

   task automatic issue(input int op, input logic [7:0] wd);
      @(negedge clk);
      req_write = op_wr(op); req_addr = op_addr(op); req_wdata = wd; req_valid = 1'b1;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
      check(!req_ready, "R12 ready during cycle", int'(req_ready), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 idle after reset
      check(cs_n && wr_n && rd_n, "R1 strobes idle", int'({cs_n, wr_n, rd_n}), 7);
      check(!ale && !bus_oe && !done, "R1 ale/oe/done", int'({ale, bus_oe, done}), 0);
      check(req_ready, "R1 ready", int'(req_ready), 1);

      for (int s = 0; s < 2; s++) begin
         slow_arb = s[0];
         for (int p = 0; p < 5; p++) begin
            for (int n = 0; n < 5; n++) begin
               int arb, need, exp_gap, target;
               logic [7:0] wd;
               string gtag;
               arb = s ? ARB_S : ARB_F;
               if (p == 0) begin need = 4 * arb; gtag = s ? "R9 R11 gap" : "R9 gap"; end
               else if (n == 0 && (p == 1 || p == 2)) begin need = 5 * arb; gtag = s ? "R10 R11 gap" : "R10 gap"; end
               else begin need = 0; gtag = "R8 gap"; end
               exp_gap = (need > NAT) ? need : NAT;
               seed = 5'(s * 25 + p * 5 + n);
               wd = 8'h30 + 8'(3 * (s * 25 + p * 5 + n));
               @(negedge clk); #1;
               target = done_cnt + 2;
               issue(p, ~wd);
               issue(n, wd);
               while (done_cnt < target) begin @(negedge clk); #1; end
               repeat (6) @(negedge clk);
               #1;
               check(last_gap == exp_gap, gtag, last_gap, exp_gap);
               check(last_ale_w == A_EXP, "R2 ale width", last_ale_w, A_EXP);
               check(lat_addr == op_addr(n), "R2 latched address", int'(lat_addr), int'(op_addr(n)));
               check(last_ats == L_EXP, "R3 ale-to-strobe", last_ats, L_EXP);
               if (op_wr(n)) begin
                  check(last_low_w == SW_EXP, "R4 write strobe width", last_low_w, SW_EXP);
                  check(wd_seen == wd, "R4 write data", int'(wd_seen), int'(wd));
                  check(post_cnt == H_EXP && post_drv == H_EXP, "R4 write hold",
                        post_cnt * 100 + post_drv, H_EXP * 101);
               end else begin
                  check(last_low_w == SR_EXP, "R5 read strobe width", last_low_w, SR_EXP);
                  check(post_drv == 0, "R5 drivers off after read", post_drv, 0);
                  check(done_rdata == rd_val(op_addr(n), seed), "R6 read data",
                        int'(done_rdata), int'(rd_val(op_addr(n), seed)));
               end
               check(done_cnt == target, "R6 done count", done_cnt, target);
            end
         end
      end

      check(oe_bad == 0, "R5 drive during read", oe_bad, 0);
      check(both_low == 0, "R7 both strobes low", both_low, 0);
      check(done_long == 0, "R6 done wider than one cycle", done_long, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule